// File: doc/BRIEF.md
# XOR Chain Connectivity Tester

This block is the tester side of a board connectivity check built on an XOR chain. The chain under test takes `N_PINS` input pins and has one output. On a good board that output is the inverted parity of its inputs. A start pulse launches one run. The block then drives a thermometer sequence onto the chain inputs, beginning with all zeros and adding one more high pin per step from pin 0 upward, until every pin is high. That gives `N_PINS + 1` vectors in total.

Each vector is held for a settle interval, and then the chain output is sampled. The sampled value is compared with the expected value, which alternates 1, 0, 1, ... starting from the all-zero vector. A pin shorted to supply or ground, or left floating, flips the parity for some of the vectors and shows up as a mismatch.

The run always visits every vector. It records the index of the first vector that mismatched and counts every mismatch. At the end it pulses `done_o` and presents pass or fail. The results stay valid until the next run starts.

Top module: `xor_chain_tester`

## Requirements
- R1: After reset, `chain_in_o`, `busy_o`, `done_o`, `pass_o`, `fail_seen_o`, `fail_idx_o` and `mismatch_cnt_o` are all zero.
- R2: While idle, `chain_in_o` is all zeros. A `start_i` high at a clock edge while idle sets `busy_o` and applies vector 0 (all zeros) from that edge onward.
- R3: Vector k (k = 0 .. N_PINS) drives bits 0 .. k-1 of `chain_in_o` high and the rest low. Every change of `chain_in_o` during a run sets exactly one more bit, the lowest low bit, so N_PINS+1 distinct vectors are applied.
- R4: The expected chain output for vector k is 1 when k is even and 0 when k is odd.
- R5: The settle value S on `settle_cycles_i` is captured at the start edge, and changing the input later has no effect on that run. Each vector is held for S+1 cycles, and `chain_out_i` is sampled at the last edge of that hold.
- R6: `done_o` is high for exactly one cycle. It is raised by the edge that falls (N_PINS+1)*(S+1) cycles after the start edge, and `busy_o` drops at that same edge.
- R7: `mismatch_cnt_o` counts every vector whose sample differs from the expected value. `fail_seen_o` sets and `fail_idx_o` latches the index of the first such vector. The run always completes all vectors.
- R8: `pass_o` is high only after a run has completed with a mismatch count of zero. All results hold until the next start and are cleared at that start.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The run's timing and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| settle_cycles_i | input | SETTLE_W | Extra hold cycles per vector |
| chain_out_i | input | 1 | Sampled XOR chain output |
| chain_in_o | output | N_PINS | Vector driven onto the chain inputs |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Completed run with no mismatch |
| fail_seen_o | output | 1 | At least one mismatch in the last run |
| fail_idx_o | output | IDX_W | Index of the first mismatching vector |
| mismatch_cnt_o | output | IDX_W | Number of mismatching vectors |

## Verification
The checker assumes that `start_i` and `chain_out_i` always hold known values. It also assumes that reset is applied before the first start. The bench drives both inputs from a known value at time zero and holds reset for several cycles. The bench's chain model is a parity gate followed by two registers, with optional stuck-high and stuck-low masks, and its output is reset to the good all-zero value. Settle values of at least 2 are used for the fault runs, so that stale samples only appear in the run that deliberately uses too short a settle.

// File: rtl/xor_chain_tester.sv
module xor_chain_tester #(
  parameter int N_PINS   = 6,
  parameter int SETTLE_W = 8,
  parameter int IDX_W    = $clog2(N_PINS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                chain_out_i,
  output logic [N_PINS-1:0]   chain_in_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic                fail_seen_o,
  output logic [IDX_W-1:0]    fail_idx_o,
  output logic [IDX_W-1:0]    mismatch_cnt_o
);
  localparam logic [IDX_W-1:0] LAST_VEC = IDX_W'(N_PINS);

  logic                busy_q, done_q, valid_q, seen_q;
  logic [IDX_W-1:0]    vec_q, first_q, cnt_q;
  logic [SETTLE_W-1:0] wait_q, settle_q;

  wire expect_bit = ~vec_q[0];
  wire sample_now = busy_q && (wait_q == settle_q);
  wire miss       = sample_now && (chain_out_i != expect_bit);
  wire last_vec   = (vec_q == LAST_VEC);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign chain_in_o[i] = busy_q && (vec_q > IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      seen_q   <= 1'b0;
      vec_q    <= '0;
      first_q  <= '0;
      cnt_q    <= '0;
      wait_q   <= '0;
      settle_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          valid_q  <= 1'b0;
          seen_q   <= 1'b0;
          vec_q    <= '0;
          first_q  <= '0;
          cnt_q    <= '0;
          wait_q   <= '0;
          settle_q <= settle_cycles_i;
        end
      end else if (sample_now) begin
        if (miss) begin
          cnt_q <= cnt_q + 1'b1;
          if (!seen_q) begin
            seen_q  <= 1'b1;
            first_q <= vec_q;
          end
        end
        if (last_vec) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
        end else begin
          vec_q  <= vec_q + 1'b1;
          wait_q <= '0;
        end
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  assign busy_o         = busy_q;
  assign done_o         = done_q;
  assign pass_o         = valid_q && (cnt_q == '0);
  assign fail_seen_o    = seen_q;
  assign fail_idx_o     = first_q;
  assign mismatch_cnt_o = cnt_q;
endmodule

module xor_chain_tester_chk #(
  parameter int N_PINS = 6,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [N_PINS-1:0] chain_in_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_seen_o,
  input logic [IDX_W-1:0]  mismatch_cnt_o
);
  localparam logic [N_PINS-1:0] ALL_ONES = '1;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> chain_in_o == '0);  // R2
  AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_in_o & (chain_in_o + 1'b1)) == '0);  // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && (chain_in_o != $past(chain_in_o))
      |-> chain_in_o == (($past(chain_in_o) << 1) | 1'b1));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R6
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o && $past(busy_o) && $past(chain_in_o) == ALL_ONES);  // R6
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> mismatch_cnt_o == '0 && !fail_seen_o && !busy_o);  // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && chain_in_o != ALL_ONES |=> busy_o);  // R9
  AST_SEEN_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen_o == (mismatch_cnt_o != '0));  // R7
endmodule

bind xor_chain_tester xor_chain_tester_chk #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_in_o(chain_in_o),
  .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
  .fail_seen_o(fail_seen_o), .mismatch_cnt_o(mismatch_cnt_o)
);

// File: tb/xor_chain_tester_bench.sv
module xor_chain_tester_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int SW = 8;
  localparam int IW = $clog2(N + 2);
  localparam int ROWS = 8;
  // stuck-high mask, stuck-low mask, settle, expected first index, expected count
  localparam int T_S1  [ROWS] = '{0,    4, 0,    0,    32, 1, 0,  63};
  localparam int T_S0  [ROWS] = '{0,    0, 1,    32,   0,  2, 0,  0};
  localparam int T_SET [ROWS] = '{3,    2, 2,    2,    4,  2, 1,  2};
  localparam int T_FI  [ROWS] = '{0,    0, 1,    6,    0,  0, 1,  1};
  localparam int T_CNT [ROWS] = '{0,    3, 6,    1,    6,  6, 6,  3};

  logic clk = 0, rst_n = 0, start = 0, chain_out;
  logic [SW-1:0] settle = '0;
  logic [N-1:0] chain_in, s1 = '0, s0 = '0;
  logic busy, done, pass, seen;
  logic [IW-1:0] fidx, cnt;
  logic d1, d2;
  int total = 0, bad = 0, steps = 0, seq_err = 0;
  logic [N-1:0] prev_in = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin d1 <= 1'b1; d2 <= 1'b1; end
    else begin d1 <= ~^((chain_in | s1) & ~s0); d2 <= d1; end
  end
  assign chain_out = d2;

  xor_chain_tester #(.N_PINS(N), .SETTLE_W(SW)) u_xor_chain_tester (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_cycles_i(settle),
    .chain_out_i(chain_out), .chain_in_o(chain_in), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_seen_o(seen), .fail_idx_o(fidx), .mismatch_cnt_o(cnt));

  always @(negedge clk) begin
    if (chain_in != prev_in) begin
      if (chain_in == ((prev_in << 1) | 1'b1)) steps++;
      else if (chain_in != '0) seq_err++;
    end
    prev_in = chain_in;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int m1, input int m0, input int st, input int fi,
                     input int ec, input bit poke, input string tag);
    int cyc = 0;
    int expc = (N + 1) * (st + 1);
    s1 = N'(m1); s0 = N'(m0); settle = SW'(st);
    repeat (st + 4) @(negedge clk);
    steps = 0; seq_err = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && chain_in == '0 && pass == 0 && cnt == 0, {tag, " R2 run begins at vector 0"},
        int'(chain_in), 0);
    while (!done && cyc < 1000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (poke && cyc == 3) begin start = 1; settle = SW'(st + 7); end
      else start = 0;
    end
    start = 0;
    chk(cyc == expc, {tag, " R5 R6 done timing"}, cyc, expc);
    chk(busy == 0, {tag, " R6 busy dropped"}, int'(busy), 0);
    chk(steps == N && seq_err == 0, {tag, " R3 thermometer steps"}, steps, N);
    chk(int'(cnt) == ec, {tag, " R7 mismatch count"}, int'(cnt), ec);
    if (ec != 0) chk(seen && int'(fidx) == fi, {tag, " R7 first failing vector"}, int'(fidx), fi);
    chk(pass == (ec == 0), {tag, " R4 R8 pass"}, int'(pass), int'(ec == 0));
    @(negedge clk);
    chk(done == 0, {tag, " R6 done one cycle"}, int'(done), 0);
    chk(pass == (ec == 0) && int'(cnt) == ec, {tag, " R8 results held"}, int'(cnt), ec);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(chain_in == '0 && !busy && !done && !pass && !seen && fidx == '0 && cnt == '0,
        "R1 reset state", int'({busy, done, pass, seen}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(chain_in == '0 && !busy, "R2 idle drives zeros", int'(chain_in), 0);

    for (int r = 0; r < ROWS; r++)
      run(T_S1[r], T_S0[r], T_SET[r], T_FI[r], T_CNT[r], 1'b0, $sformatf("row%0d", r));

    // R9 ignored start and R5 late settle change, on a clean chain
    run(0, 0, 2, 0, 0, 1'b1, "R9 start while busy");
    // R9 on a faulty chain: results must match the unpoked run
    run(4, 0, 3, 0, 3, 1'b1, "R9 faulty chain");
    // R8 results cleared at next start
    s1 = N'(4); s0 = '0; settle = SW'(2);
    run(4, 0, 2, 0, 3, 1'b0, "R8 prep");
    start = 1; s1 = '0;
    @(negedge clk);
    start = 0;
    chk(!seen && cnt == '0 && !pass, "R8 cleared at start", int'(cnt), 0);
    while (busy) @(negedge clk);
    chk(pass == 1, "R8 pass after clean rerun", int'(pass), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule